// File: doc/BRIEF.md
# PWM Fault Latch and Override

This block sits between a PWM generator and the output pins. It watches two independent active-low fault inputs, A and B. While either enabled fault is in force, it replaces every PWM output bit with a software-programmed safe level. A low level on a fault input counts as a fault. A broken wire that gets pulled low therefore also trips the block.

Each fault input passes through a two-flop synchroniser. It then feeds its own three-state channel machine:

- IDLE: no override.
- TRIPPED: fault in force, outputs overridden.
- RESUME: fault gone, outputs still overridden until a boundary arrives.

The named transitions are:

- trip: IDLE or RESUME to TRIPPED, on a synchronised low input while enabled. Trip sets the channel flag.
- unlock: TRIPPED to RESUME. In latched mode this needs the input high and the flag cleared. In cycle-by-cycle mode it needs only the input high.
- resume: RESUME to IDLE, on a period or half-period boundary tick from the external timebase.
- disable: any state to IDLE, when the channel enable is clear.

Reset puts both channels in TRIPPED with both flags set, both enabled and both latched. The outputs therefore start in the safe state until software clears the faults.

Software reaches the block through a small register port with three registers:

- control (address 0)
- safe level (address 1)
- fault flags (address 2), which are cleared by writing 1.

The OR of the two flags drives the fault interrupt output.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, the control register (address 0) reads 0xF, the flag register (address 2) reads 0x3 and fault_irq is 1. Both channels are in TRIPPED, so pwm_out shows the safe level. Control bit 0 enables A, bit 1 enables B, bit 2 selects latched mode for A and bit 3 selects latched mode for B.
- R2: A low level on either enabled fault input overrides all pwm_out bits with the safe level. The override is in place no later than the third rising clock edge after the input falls.
- R3: The trip transition sets that channel's flag: bit 0 for A, bit 1 for B of address 2. fault_irq is the OR of the two flags.
- R4: A write of 1 to a flag bit is ignored while that channel's synchronised fault input is still low. The flag keeps reading 1.
- R5: In latched mode, the fault input returning high does not release the outputs, even across boundary ticks, until the flag has been cleared.
- R6: After unlock, pwm_out stays at the safe level until the first period_tick or half_tick. After the clock edge that samples that tick, pwm_out follows pwm_in.
- R7: In cycle-by-cycle mode (latched bit 0), a fault input returning high releases the outputs at the next boundary without any flag clear. The flag stays set until software clears it.
- R8: The safe level register (address 1, N_OUT bits) resets to all zeros, and a write sets the level driven during an override.
- R9: While a channel's enable bit is 0, its fault input neither overrides pwm_out nor sets its flag.
- R10: While either channel is TRIPPED or RESUME, pwm_out stays at the safe level, even when the other channel has returned to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | N_OUT | Raw PWM outputs from the generator |
| flt_a_n | input | 1 | Fault input A, active low |
| flt_b_n | input | 1 | Fault input B, active low |
| period_tick | input | 1 | One-cycle pulse at each PWM period boundary |
| half_tick | input | 1 | One-cycle pulse at each PWM half-period boundary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DW | Register read data, combinational |
| pwm_out | output | N_OUT | Gated PWM outputs |
| fault_irq | output | 1 | Fault interrupt, OR of the flags |

## Verification
The bench tries to clear a flag while its input is still low. A design that honoured that write would drop the latch and release the outputs during a live fault. It lets a latched input return high across a boundary with the flag still set, which catches a design that treats latched mode as cycle-by-cycle. It checks that the outputs stay in the safe state between unlock and the first tick, which would fail if restoration happened immediately. It also releases one fault while the other is still held, and feeds a fault into a disabled channel. A design that gated the outputs on only one channel, or ignored the enable, would release early or trip wrongly in those cases.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int NUM_CH = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SAFE = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    // control register layout
    localparam int CTRL_EN_LSB    = 0;
    localparam int CTRL_LATCH_LSB = 2;
    localparam int CTRL_W         = 4;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_TRIPPED = 2'd1,
        CH_RESUME  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Resets to 0: an unknown input is treated as an asserted fault.
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];

endmodule

// File: rtl/pfg_channel.sv
module pfg_channel
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_s,
    input  logic enable,
    input  logic latched,
    input  logic boundary,
    input  logic clr_req,
    output logic hold,
    output logic flag
);
    ch_state_e state_q, state_d;
    logic      flag_q, flag_d;
    logic      pin_low;
    logic      trip_evt;

    assign pin_low = ~pin_n_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_TRIPPED;
            flag_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = CH_IDLE;                      // disable
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (pin_low) state_d = CH_TRIPPED;  // trip
                end
                CH_TRIPPED: begin
                    if (!pin_low && (!latched || !flag_q))
                        state_d = CH_RESUME;            // unlock
                end
                CH_RESUME: begin
                    if (pin_low)       state_d = CH_TRIPPED; // trip again
                    else if (boundary) state_d = CH_IDLE;    // resume
                end
                default: state_d = CH_TRIPPED;
            endcase
        end
    end

    assign trip_evt = enable && pin_low &&
                      (state_q == CH_IDLE || state_q == CH_RESUME);

    // flag: set wins over clear; clear only with the pin released
    always_comb begin
        flag_d = flag_q;
        if (trip_evt)                flag_d = 1'b1;
        else if (clr_req && !pin_low) flag_d = 1'b0;
    end

    // outputs
    always_comb begin
        hold = (state_q != CH_IDLE);
        flag = flag_q;
    end

    // R4
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && pin_low) |=> flag_q);

    // R3
    flag_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pin_low && state_q == CH_IDLE) |=> (flag_q && state_q == CH_TRIPPED));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && latched && state_q == CH_TRIPPED && flag_q) |=> (state_q == CH_TRIPPED));

    // R6
    resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == CH_RESUME && !boundary && !pin_low) |=> (state_q == CH_RESUME));

    // R7
    cycle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !latched && state_q == CH_TRIPPED && !pin_low) |=> (state_q == CH_RESUME));

    // R9
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (state_q == CH_IDLE && !hold));

endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
    import pfg_pkg::*;
#(
    parameter int N_OUT  = 6,
    parameter int DW     = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NUM_CH-1:0] flags,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] ch_latched,
    output logic [N_OUT-1:0]  safe_lvl,
    output logic [NUM_CH-1:0] clr_req,
    output logic [DW-1:0]     rd_data
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [N_OUT-1:0]  safe_q;
    logic              wr_ctrl, wr_safe, wr_flag;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_safe = wr_en && (wr_addr == ADDR_W'(ADDR_SAFE));
    assign wr_flag = wr_en && (wr_addr == ADDR_W'(ADDR_FLAG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '1;       // both enabled, both latched
            safe_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_safe) safe_q <= wr_data[N_OUT-1:0];
        end
    end

    always_comb begin
        ch_en      = ctrl_q[CTRL_EN_LSB +: NUM_CH];
        ch_latched = ctrl_q[CTRL_LATCH_LSB +: NUM_CH];
        safe_lvl   = safe_q;
        clr_req    = wr_flag ? wr_data[NUM_CH-1:0] : '0;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(ADDR_CTRL): rd_data[CTRL_W-1:0] = ctrl_q;
            ADDR_W'(ADDR_SAFE): rd_data[N_OUT-1:0]  = safe_q;
            ADDR_W'(ADDR_FLAG): rd_data[NUM_CH-1:0] = flags;
            default:            rd_data = '0;
        endcase
    end

    // R8
    safe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_safe |=> (safe_lvl == $past(wr_data[N_OUT-1:0])));

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int N_OUT       = 6,
    parameter int DW          = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OUT-1:0]  pwm_in,
    input  logic              flt_a_n,
    input  logic              flt_b_n,
    input  logic              period_tick,
    input  logic              half_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [N_OUT-1:0]  pwm_out,
    output logic              fault_irq
);
    logic [NUM_CH-1:0] pin_raw, pin_s;
    logic [NUM_CH-1:0] ch_en, ch_latched, clr_req, hold, flags;
    logic [N_OUT-1:0]  safe_lvl;
    logic              boundary;
    logic              any_hold;

    assign pin_raw  = {flt_b_n, flt_a_n};
    assign boundary = period_tick | half_tick;

    pfg_regs #(.N_OUT(N_OUT), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .flags      (flags),
        .ch_en      (ch_en),
        .ch_latched (ch_latched),
        .safe_lvl   (safe_lvl),
        .clr_req    (clr_req),
        .rd_data    (rd_data)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (pin_raw[c]),
                .q     (pin_s[c])
            );

            pfg_channel u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_n_s  (pin_s[c]),
                .enable   (ch_en[c]),
                .latched  (ch_latched[c]),
                .boundary (boundary),
                .clr_req  (clr_req[c]),
                .hold     (hold[c]),
                .flag     (flags[c])
            );

            // R2
            fault_forces_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_en[c] && !pin_s[c]) |=> (pwm_out == safe_lvl));
        end
    endgenerate

    assign any_hold = |hold;

    always_comb begin
        pwm_out   = any_hold ? safe_lvl : pwm_in;
        fault_irq = |flags;
    end

    // R10
    resume_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[0] && !hold[1]) |-> (pwm_out == safe_lvl));

endmodule

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
    localparam int N_OUT = 6;
    localparam int DW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_OUT-1:0] pwm_in = 6'h2A;
    logic             flt_a_n = 1'b1, flt_b_n = 1'b1;
    logic             period_tick = 1'b0, half_tick = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0, rd_addr = 2'd0;
    logic [DW-1:0]    wr_data = '0;
    logic [DW-1:0]    rd_data;
    logic [N_OUT-1:0] pwm_out;
    logic             fault_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_fault_guard u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .flt_a_n(flt_a_n), .flt_b_n(flt_b_n),
        .period_tick(period_tick), .half_tick(half_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .fault_irq(fault_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick(input bit half);
        @(negedge clk);
        if (half) half_tick = 1'b1; else period_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0; period_tick = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        reg_rd(2'd0, v); chk("R1 ctrl reset", v, 16'h000F);
        reg_rd(2'd2, v); chk("R1 flags reset", v, 16'h0003);
        chk("R1 irq reset", 16'(fault_irq), 16'h1);
        chk("R1 pwm_out safe at reset", 16'(pwm_out), 16'h0);
        reg_rd(2'd1, v); chk("R8 safe level reset", v, 16'h0000);
    endtask

    task automatic t_startup_release;
        logic [15:0] v;
        reg_wr(2'd2, 16'h3);
        cycles(3);
        reg_rd(2'd2, v); chk("R3 flags cleared", v, 16'h0);
        chk("R3 irq low", 16'(fault_irq), 16'h0);
        chk("R6 safe until boundary", 16'(pwm_out), 16'h0);
        tick(1'b1);
        chk("R6 restored on half tick", 16'(pwm_out), 16'h2A);
    endtask

    task automatic t_trip_a;
        logic [15:0] v;
        reg_wr(2'd1, 16'h15);
        reg_rd(2'd1, v); chk("R8 safe level readback", v, 16'h15);
        @(negedge clk); flt_a_n = 1'b0;
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R2 fault A forces safe", 16'(pwm_out), 16'h15);
        reg_rd(2'd2, v); chk("R3 flag A set", v, 16'h1);
        chk("R3 irq set", 16'(fault_irq), 16'h1);
    endtask

    task automatic t_clear_blocked;
        logic [15:0] v;
        reg_wr(2'd2, 16'h1);
        cycles(1);
        reg_rd(2'd2, v); chk("R4 clear ignored while low", v, 16'h1);
        chk("R4 still safe", 16'(pwm_out), 16'h15);
    endtask

    task automatic t_latched_hold;
        logic [15:0] v;
        flt_a_n = 1'b1;
        cycles(4);
        tick(1'b0);
        cycles(1);
        chk("R5 latched holds without clear", 16'(pwm_out), 16'h15);
        reg_wr(2'd2, 16'h1);
        cycles(3);
        reg_rd(2'd2, v); chk("R5 flag cleared", v, 16'h0);
        chk("R6 safe after unlock before tick", 16'(pwm_out), 16'h15);
        tick(1'b0);
        chk("R6 restored on period tick", 16'(pwm_out), 16'h2A);
    endtask

    task automatic t_both_faults;
        logic [15:0] v;
        @(negedge clk); flt_b_n = 1'b0; flt_a_n = 1'b0;
        cycles(4);
        chk("R2 fault B forces safe", 16'(pwm_out), 16'h15);
        reg_rd(2'd2, v); chk("R3 both flags", v, 16'h3);
        flt_a_n = 1'b1;
        cycles(4);
        reg_wr(2'd2, 16'h1);
        cycles(3);
        tick(1'b1);
        cycles(1);
        chk("R10 B keeps outputs safe", 16'(pwm_out), 16'h15);
        reg_rd(2'd2, v); chk("R10 only flag B left", v, 16'h2);
        flt_b_n = 1'b1;
        cycles(4);
        reg_wr(2'd2, 16'h2);
        cycles(3);
        tick(1'b0);
        chk("R10 released after B", 16'(pwm_out), 16'h2A);
    endtask

    task automatic t_cycle_mode;
        logic [15:0] v;
        reg_wr(2'd0, 16'h3);
        pwm_in = 6'h33;
        @(negedge clk); flt_a_n = 1'b0;
        cycles(4);
        chk("R7 cycle mode trips", 16'(pwm_out), 16'h15);
        flt_a_n = 1'b1;
        cycles(4);
        chk("R7 waits for boundary", 16'(pwm_out), 16'h15);
        tick(1'b1);
        chk("R7 released without clear", 16'(pwm_out), 16'h33);
        reg_rd(2'd2, v); chk("R7 flag stays set", v, 16'h1);
        reg_wr(2'd2, 16'h1);
        cycles(1);
        reg_rd(2'd2, v); chk("R7 flag cleared by write", v, 16'h0);
    endtask

    task automatic t_disabled;
        logic [15:0] v;
        reg_wr(2'd0, 16'hE);
        @(negedge clk); flt_a_n = 1'b0;
        cycles(5);
        chk("R9 disabled A no override", 16'(pwm_out), 16'h33);
        reg_rd(2'd2, v); chk("R9 disabled A no flag", v, 16'h0);
        chk("R9 irq low", 16'(fault_irq), 16'h0);
        flt_a_n = 1'b1;
        cycles(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_startup_release();
        t_trip_a();
        t_clear_blocked();
        t_latched_hold();
        t_both_faults();
        t_cycle_mode();
        t_disabled();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule